// File: doc/BRIEF.md
# Polyphase Parallel Carrier Oscillator

This block synthesizes a digital RF carrier whose frequency lies above the Nyquist limit of the fabric clock. On every fabric cycle it emits one vector of sixteen cosine samples and one vector of sixteen sine samples. Each vector holds sixteen consecutive samples of one carrier at sixteen times the fabric rate. With a 256 MHz fabric clock, a serializer can stream these vectors to a 4.096 GS/s DAC. A single oscillator at fabric rate could only reach 128 MHz. The sixteen phase-offset lanes together cover the whole 55 MHz to 880 MHz carrier band.

The frequency is set by a 32-bit tuning word equal to fout / 4.096 GHz × 2^32. In whole megahertz this is simply f_MHz × 2^20, so 860 MHz is 0x35C0_0000. A phase clear input restarts the carrier at zero phase. Lane k adds k tuning words to a shared base phase, and the base phase advances by sixteen tuning words per cycle. Every lane reads a quarter-wave sine table with the top bits of its phase.

Top module: `pnco_carrier_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both output vectors read all zeros, and the base phase and the captured tuning word are both zero.
- R2: Lane k occupies bits [16k+15:16k] of each output vector. Its sample equals the lookup of base phase + k × captured tuning word (mod 2^32). Lane 0 is the oldest sample and lane 15 the newest.
- R3: When no clear is applied, the base phase behind consecutive vectors advances by 16 × captured tuning word (mod 2^32). The sample sequence therefore runs on from lane 15 of one vector into lane 0 of the next with no phase jump.
- R4: `tune_word` is captured at every clock edge and governs all sixteen lanes of the vector registered at the following edge. The base phase continues from where the previous word left it.
- R5: A `phase_clr` sampled high at an edge zeroes the base phase. The vector registered at the next edge then has lane 0 cosine = 32767 and sine = 0, and the later lanes step by the captured word.
- R6: A lane's table address is the top 10 bits of its phase. Its sine is round(32767 · sin(2π·a/1024)), rounded symmetrically about zero. Its cosine is the sine at address (a+256) mod 1024. Both are 16-bit two's complement.
- R7: A tuning word of zero makes all sixteen lanes identical and constant from vector to vector.
- R8: A tuning word of 0x8000_0000, which is half the aggregate rate, puts adjacent lanes half a cycle apart. The lane cosines then alternate in sign.
- R9: The band-edge words 0x0370_0000 (55 MHz) and 0x3700_0000 (880 MHz) produce carriers that follow R2 and R3 over many vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Frequency tuning word, captured every cycle |
| phase_clr | input | 1 | Zeroes the base phase at the sampling edge |
| cos_o | output | 256 | Sixteen 16-bit cosine samples, lane 0 in the low bits |
| sin_o | output | 256 | Sixteen 16-bit sine samples, lane 0 in the low bits |

## Verification
A corrupted base phase appears at once in the next vector, in all thirty-two samples together, as a rotation of the carrier. A wrong stride shows up one vector later, as a break between lane 15 and the following lane 0. A wrong captured tuning word alters the spacing between lanes inside a single vector. A table folding error shows up only at particular addresses. A slow sweep therefore visits all 1024 addresses so that each quadrant edge reaches the ports within about seventy cycles.

// File: rtl/pnco_pkg.sv
package pnco_pkg;

   localparam real PNCO_PI = 3.14159265358979323846;

   // Rounded magnitude of point i of a quarter sine wave split into qtr steps
   function automatic int quarter_point(input int i, input int qtr, input int amp);
      real v;
      v = real'(amp) * $sin(PNCO_PI * real'(i) / (2.0 * real'(qtr)));
      return $rtoi(v + 0.5);
   endfunction

endpackage

// File: rtl/pnco_phase_acc.sv
module pnco_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int LANES   = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] tune_word,
   input  logic               phase_clr,
   output logic [PHASE_W-1:0] base_o,
   output logic [PHASE_W-1:0] ftw_o
);

   localparam bit LANES_POW2 = ((LANES & (LANES - 1)) == 0);

   logic [PHASE_W-1:0] stride;

   generate
      if (LANES_POW2) begin : g_shift
         assign stride = ftw_o << $clog2(LANES);
      end else begin : g_mul
         assign stride = ftw_o * PHASE_W'(LANES);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ftw_o  <= '0;
         base_o <= '0;
      end else begin
         ftw_o  <= tune_word;
         base_o <= phase_clr ? '0 : base_o + stride;
      end
   end

   // R3 and R4: a word on the port sets the step of the base two edges later
   a_r3_base_stride : assert property (@(posedge clk) disable iff (rst)
      (!phase_clr ##1 !phase_clr) |=>
         ((base_o - $past(base_o)) == PHASE_W'(PHASE_W'(LANES) * $past(tune_word, 2))));

endmodule

// File: rtl/pnco_sine_lut.sv
module pnco_sine_lut #(
   parameter int ADDR_W = 10,
   parameter int SAMP_W = 16
) (
   input  logic [ADDR_W-1:0]        addr_i,
   output logic signed [SAMP_W-1:0] sin_o,
   output logic signed [SAMP_W-1:0] cos_o
);

   localparam int QTR = 2 ** (ADDR_W - 2);
   localparam int AMP = 2 ** (SAMP_W - 1) - 1;
   localparam int TAB_W = (QTR + 1) * SAMP_W;

   function automatic logic [TAB_W-1:0] build_tab();
      logic [TAB_W-1:0] t;
      t = '0;
      for (int i = 0; i <= QTR; i++)
         t[i*SAMP_W +: SAMP_W] = SAMP_W'(pnco_pkg::quarter_point(i, QTR, AMP));
      return t;
   endfunction

   localparam logic [TAB_W-1:0] QTAB = build_tab();

   // Quadrant fold: bit 0 of the quadrant mirrors the index, bit 1 negates
   function automatic logic signed [SAMP_W-1:0] fold(input logic [ADDR_W-1:0] a);
      logic [1:0]        quad;
      logic [ADDR_W-3:0] ix;
      int                off;
      logic [SAMP_W-1:0] mag;
      quad = a[ADDR_W-1 -: 2];
      ix   = a[ADDR_W-3:0];
      off  = quad[0] ? (QTR - int'(ix)) : int'(ix);
      mag  = QTAB[off*SAMP_W +: SAMP_W];
      return quad[1] ? -signed'(mag) : signed'(mag);
   endfunction

   always_comb begin
      sin_o = fold(addr_i);
      cos_o = fold(addr_i + ADDR_W'(QTR));
   end

endmodule

// File: rtl/pnco_carrier_gen.sv
module pnco_carrier_gen #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 10,
   parameter int SAMP_W  = 16,
   parameter int LANES   = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [PHASE_W-1:0]        tune_word,
   input  logic                      phase_clr,
   output logic [LANES*SAMP_W-1:0]   cos_o,
   output logic [LANES*SAMP_W-1:0]   sin_o
);

   localparam int     AMP     = 2 ** (SAMP_W - 1) - 1;
   localparam longint RADIUS2 = longint'(AMP) * longint'(AMP);
   localparam longint SLACK   = 2 * longint'(AMP);

   generate
      if (ADDR_W < 3 || ADDR_W > PHASE_W) begin : g_bad_addr
         $error("pnco_carrier_gen: ADDR_W must be within 3..PHASE_W");
      end
      if (SAMP_W < 4 || SAMP_W > 24) begin : g_bad_samp
         $error("pnco_carrier_gen: SAMP_W must be within 4..24");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("pnco_carrier_gen: LANES must be at least 1");
      end
   endgenerate

   logic [PHASE_W-1:0] base;
   logic [PHASE_W-1:0] ftw;

   pnco_phase_acc #(
      .PHASE_W (PHASE_W),
      .LANES   (LANES)
   ) u_acc (
      .clk       (clk),
      .rst       (rst),
      .tune_word (tune_word),
      .phase_clr (phase_clr),
      .base_o    (base),
      .ftw_o     (ftw)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [ADDR_W-1:0]        lane_addr;
      logic signed [SAMP_W-1:0] lut_cos;
      logic signed [SAMP_W-1:0] lut_sin;
      logic [SAMP_W-1:0]        cos_q;
      logic [SAMP_W-1:0]        sin_q;

      assign lane_addr = ADDR_W'((base + PHASE_W'(k) * ftw) >> (PHASE_W - ADDR_W));

      pnco_sine_lut #(
         .ADDR_W (ADDR_W),
         .SAMP_W (SAMP_W)
      ) u_lut (
         .addr_i (lane_addr),
         .sin_o  (lut_sin),
         .cos_o  (lut_cos)
      );

      always_ff @(posedge clk) begin
         if (rst) begin
            cos_q <= '0;
            sin_q <= '0;
         end else begin
            cos_q <= lut_cos;
            sin_q <= lut_sin;
         end
      end

      assign cos_o[k*SAMP_W +: SAMP_W] = cos_q;
      assign sin_o[k*SAMP_W +: SAMP_W] = sin_q;

      // R6: the two table reads of a lane stay on the unit circle
      a_r6_on_circle : assert property (@(posedge clk) disable iff (rst)
         ((longint'(lut_cos) * longint'(lut_cos) + longint'(lut_sin) * longint'(lut_sin)
              <= RADIUS2 + SLACK) &&
          (longint'(lut_cos) * longint'(lut_cos) + longint'(lut_sin) * longint'(lut_sin)
              >= RADIUS2 - SLACK)));

      if (k > 0) begin : g_flat
         // R7: a zero word collapses every lane onto lane 0
         a_r7_zero_word_flat : assert property (@(posedge clk) disable iff (rst)
            (tune_word == '0) |=> ##1
               ((cos_o[k*SAMP_W +: SAMP_W] == cos_o[SAMP_W-1:0]) &&
                (sin_o[k*SAMP_W +: SAMP_W] == sin_o[SAMP_W-1:0])));
      end
   end

   // R5: a clear makes lane 0 of the vector after next start at zero phase
   a_r5_clear_start : assert property (@(posedge clk) disable iff (rst)
      phase_clr |=> ##1
         ((cos_o[SAMP_W-1:0] == SAMP_W'(AMP)) && (sin_o[SAMP_W-1:0] == '0)));

endmodule

// File: tb/test_pnco_carrier_gen.sv
module test_pnco_carrier_gen;

   localparam int LANES = 16;
   localparam int W     = 16;

   logic              clk = 1'b0;
   logic              rst;
   logic [31:0]       tune_word;
   logic              phase_clr;
   logic [LANES*W-1:0] cos_o;
   logic [LANES*W-1:0] sin_o;

   always #5 clk = ~clk;

   pnco_carrier_gen i_pnco_carrier_gen (
      .clk       (clk),
      .rst       (rst),
      .tune_word (tune_word),
      .phase_clr (phase_clr),
      .cos_o     (cos_o),
      .sin_o     (sin_o)
   );

   int checks = 0;
   int fails  = 0;

   // Model state: base phase and captured word seen by the next edge
   logic [31:0] base_m;
   logic [31:0] ftwq_m;

   logic [LANES*W-1:0] exp_cos_q[$];
   logic [LANES*W-1:0] exp_sin_q[$];
   string              tag_q[$];

   function automatic int ref_sin(input int a);
      real v;
      v = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(a) / 1024.0);
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(-v + 0.5);
   endfunction

   // Driver: applies one cycle of stimulus and queues the vector it must yield
   task automatic drive(input logic [31:0] tw, input logic clr, input string tag);
      logic [LANES*W-1:0] ec;
      logic [LANES*W-1:0] es;
      logic [31:0]        ph;
      int                 a;
      @(negedge clk);
      tune_word = tw;
      phase_clr = clr;
      for (int k = 0; k < LANES; k++) begin
         ph = base_m + 32'(k) * ftwq_m;
         a  = int'(ph[31:22]);
         ec[k*W +: W] = 16'(ref_sin((a + 256) % 1024));
         es[k*W +: W] = 16'(ref_sin(a));
      end
      exp_cos_q.push_back(ec);
      exp_sin_q.push_back(es);
      tag_q.push_back(tag);
      base_m = clr ? 32'd0 : base_m + (ftwq_m << 4);
      ftwq_m = tw;
   endtask

   task automatic run(input logic [31:0] tw, input int n, input string tag);
      for (int i = 0; i < n; i++) drive(tw, 1'b0, tag);
   endtask

   // Monitor: pops one expected vector per edge and compares it
   always @(posedge clk) begin
      #2;
      if (exp_cos_q.size() > 0) begin
         logic [LANES*W-1:0] ec;
         logic [LANES*W-1:0] es;
         string              tg;
         ec = exp_cos_q.pop_front();
         es = exp_sin_q.pop_front();
         tg = tag_q.pop_front();
         checks++;
         if (cos_o !== ec || sin_o !== es) begin
            fails++;
            for (int k = 0; k < LANES; k++) begin
               if (cos_o[k*W +: W] !== ec[k*W +: W] || sin_o[k*W +: W] !== es[k*W +: W]) begin
                  $display("FAIL %s lane %0d: cos %0d sin %0d, expected cos %0d sin %0d",
                           tg, k, $signed(cos_o[k*W +: W]), $signed(sin_o[k*W +: W]),
                           $signed(ec[k*W +: W]), $signed(es[k*W +: W]));
                  break;
               end
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst       = 1'b1;
      tune_word = 32'h0123_4567;
      phase_clr = 1'b0;
      base_m    = '0;
      ftwq_m    = '0;
      repeat (3) @(posedge clk);
      #2;
      checks++;
      if (cos_o !== '0 || sin_o !== '0) begin
         fails++;
         $display("FAIL R1 reset outputs: cos %h sin %h, expected all zero", cos_o, sin_o);
      end
      @(negedge clk);
      rst       = 1'b0;
      tune_word = 32'h0;

      // R1: after release, zero base and zero word give cosine peak everywhere
      drive(32'h0, 1'b0, "R1");
      // R7: zero word keeps all lanes equal and constant
      run(32'h0, 3, "R7");
      // R5: clear, then the 860 MHz word; R2 lane spacing inside a vector
      drive(32'h35C0_0000, 1'b1, "R5");
      run(32'h35C0_0000, 20, "R2");
      // R4: switch to 55 MHz mid-run
      run(32'h0370_0000, 10, "R4");
      // R9: band edge at 880 MHz; R3 continuity over many vectors
      run(32'h3700_0000, 20, "R9");
      run(32'h3700_0000, 5, "R3");
      // R8: half the aggregate rate, alternating lanes
      run(32'h8000_0000, 5, "R8");
      // R5: clear in the middle of a running carrier
      drive(32'h35C0_0000, 1'b1, "R5");
      run(32'h35C0_0000, 5, "R5");
      // R6: one address step per lane sweeps every table address
      drive(32'h0040_0000, 1'b1, "R6");
      run(32'h0040_0000, 70, "R6");
      // R7: back to zero word, lanes flatten again
      run(32'h0, 4, "R7");

      repeat (4) @(posedge clk);
      #3;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule